// File: doc/BRIEF.md
# Programmable IDE PIO Strobe Timer

This block produces the read/write strobe for legacy IDE programmed I/O on a local bus. Each bus access is described by one timing byte. The low nibble sets how many bus clocks the strobe is asserted, and the high nibble sets how many bus clocks of recovery follow. Both nibbles are stored inverted, as a maximum minus the cycle count, so a code of zero gives the slowest cycle. Four timing slots can be written through a configuration port. Each access names the slot it uses.

An access request uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A requester that holds `req_valid` high while `req_ready` is low keeps its request pending, and the request is taken on the first edge after the done pulse. The slot index and both decoded counts are captured when the request is taken.

The parameter `NARROW` picks between two decodings. The wide decoding uses the full low nibble. The narrow decoding uses only bits 2:0 of the low nibble, and its ranges depend on the `fast_bus` strap, which tells the block whether the bus clock is above 33 MHz.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, all four slots hold code 8'h00. `req_ready`=1, `strobe_n`=1, `busy`=0 and `done`=0.
- R2: A write on `cfg_wr` selects its slot with `cfg_addr[7]` as index bit 0 and `cfg_addr[1]` as index bit 1. All other address bits are ignored. `req_sel` names the slot that an access uses.
- R3: Wide decoding (`NARROW`=0): the active count is 17 minus code[3:0], giving 17 down to 2. The recovery count is 15 minus code[7:4], with a minimum of 2, so high-nibble codes 14 and 15 both give 2. `fast_bus` has no effect.
- R4: Narrow decoding with `fast_bus`=0: the active count is 9 minus code[2:0], giving 9 down to 2, and code bit 3 is ignored. The recovery count is 15 minus code[7:4], giving 15 down to 0.
- R5: Narrow decoding with `fast_bus`=1: the active count is 8 minus code[2:0], giving 8 down to 1, and bit 3 is ignored. The recovery count is 18 minus code[7:4], giving 18 down to 3.
- R6: Take the accepting edge as cycle 0. `strobe_n` is low for exactly the active count of cycles, starting in cycle 1. It is then high for the recovery count of cycles. `done` is then high for exactly one cycle.
- R7: When the recovery count is zero, the `done` cycle comes right after the last active cycle.
- R8: `req_ready` is low from the cycle after acceptance through the `done` cycle, and is high in the cycle after `done`. A held request is taken only then.
- R9: The counts are captured when a request is taken. A configuration write during an access, with the same value or a new value, does not change that access. A new value applies to the next access that uses the slot.
- R10: `busy` is high exactly while `req_ready` is low. This covers the active, recovery and done cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Timing slot write strobe |
| cfg_addr | input | 8 | Write address; bits 7 and 1 select the slot |
| cfg_data | input | 8 | Timing code; low nibble active, high nibble recovery |
| fast_bus | input | 1 | Strap: 1 means the bus clock is above 33 MHz |
| req_valid | input | 1 | Access request valid |
| req_sel | input | 2 | Slot used by the requested access |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| strobe_n | output | 1 | Active-low I/O strobe |
| busy | output | 1 | Access cycle in progress |
| done | output | 1 | One-cycle pulse at the end of an access |

## Verification
The assertions take for granted that `req_valid` and `rst_n` are never unknown after time zero. They also take for granted that the requester only observes `req_ready` and does not depend on it combinationally. The stimulus meets both conditions: every input is driven to a known value before reset is released, and every input changes only at falling clock edges. Under these conditions, the handshake and phase-length properties follow from the sequencer state alone. The bench sweeps every timing code through each decoding and measures each phase length at the ports.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  localparam int CNT_W   = 5;
  localparam int SLOTS   = 4;
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int CODE_W  = 8;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  typedef struct packed {
    cnt_t act;
    cnt_t rec;
  } phase_cnt_t;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_timer_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  code_t            wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output code_t            rd_code
);
  logic [IDX_W-1:0] wr_idx;
  code_t            slot_q [SLOTS];

  // slot index: address bit 7 is index bit 0, address bit 1 is index bit 1
  assign wr_idx = {wr_addr[1], wr_addr[7]};

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= RESET_CODE;
      else if (wr_en && (wr_idx == IDX_W'(i)) && (wr_data != slot_q[i]))
        slot_q[i] <= wr_data;
    end
  end

  assign rd_code = slot_q[rd_sel];
endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timer_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  code_t      code,
  input  logic       fast_bus,
  output phase_cnt_t cnts
);
  cnt_t lo_full, lo_three, hi;

  assign lo_full  = cnt_t'(code[3:0]);
  assign lo_three = cnt_t'(code[2:0]);
  assign hi       = cnt_t'(code[7:4]);

  if (NARROW) begin : g_narrow
    always_comb begin
      if (fast_bus) begin
        cnts.act = cnt_t'(8)  - lo_three;
        cnts.rec = cnt_t'(18) - hi;
      end else begin
        cnts.act = cnt_t'(9)  - lo_three;
        cnts.rec = cnt_t'(15) - hi;
      end
    end
  end else begin : g_wide
    logic unused_fast;
    assign unused_fast = fast_bus;
    always_comb begin
      cnts.act = cnt_t'(17) - lo_full;
      cnts.rec = (code[7:4] > 4'd13) ? cnt_t'(2) : (cnt_t'(15) - hi);
    end
  end
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  phase_cnt_t cnts,
  output logic       req_ready,
  output logic       strobe_n,
  output logic       busy,
  output logic       done
);
  seq_state_t state;
  cnt_t       cnt;
  cnt_t       rec_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rec_hold <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_ACT;
          cnt      <= cnts.act - cnt_t'(1);
          rec_hold <= cnts.rec;
        end
        ST_ACT: begin
          if (cnt == '0) begin
            if (rec_hold == '0) begin
              state <= ST_DONE;
            end else begin
              state <= ST_REC;
              cnt   <= rec_hold - cnt_t'(1);
            end
          end else begin
            cnt <= cnt - cnt_t'(1);
          end
        end
        ST_REC: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - cnt_t'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign strobe_n  = (state != ST_ACT);
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_data,
  input  logic       fast_bus,
  input  logic       req_valid,
  input  logic [1:0] req_sel,
  output logic       req_ready,
  output logic       strobe_n,
  output logic       busy,
  output logic       done
);
  code_t      sel_code;
  phase_cnt_t sel_cnts;

  pio_timing_regs #(.RESET_CODE('0)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .rd_sel  (req_sel),
    .rd_code (sel_code)
  );

  pio_timing_decode #(.NARROW(NARROW)) u_dec (
    .code     (sel_code),
    .fast_bus (fast_bus),
    .cnts     (sel_cnts)
  );

  pio_strobe_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cnts      (sel_cnts),
    .req_ready (req_ready),
    .strobe_n  (strobe_n),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic strobe_n,
  input logic busy,
  input logic done
);
  logic [5:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         low_run <= '0;
    else if (!strobe_n) low_run <= (low_run == 6'h3f) ? low_run : low_run + 6'd1;
    else                low_run <= '0;
  end

  assert_accept_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !strobe_n);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_active_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> (low_run < 6'd17));
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  assert_accept_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n || done) |-> (busy && !req_ready));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && strobe_n && !done));
endmodule

bind pio_strobe_timer pio_strobe_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .strobe_n  (strobe_n),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_pio_strobe_timer.sv
`timescale 1ns/1ps
module sim_pio_strobe_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr0 = 1'b0, wr1 = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_data = '0;
  logic       fast_bus = 1'b0;
  logic       v0 = 1'b0, v1 = 1'b0;
  logic [1:0] req_sel = '0;
  logic       rdy0, stb0, bsy0, dn0;
  logic       rdy1, stb1, bsy1, dn1;
  int         tgt = 0;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  pio_strobe_timer #(.NARROW(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr0), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .fast_bus(fast_bus), .req_valid(v0), .req_sel(req_sel),
    .req_ready(rdy0), .strobe_n(stb0), .busy(bsy0), .done(dn0));

  pio_strobe_timer #(.NARROW(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr1), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .fast_bus(fast_bus), .req_valid(v1), .req_sel(req_sel),
    .req_ready(rdy1), .strobe_n(stb1), .busy(bsy1), .done(dn1));

  logic o_rdy, o_stb, o_bsy, o_dn;
  assign o_rdy = (tgt == 0) ? rdy0 : rdy1;
  assign o_stb = (tgt == 0) ? stb0 : stb1;
  assign o_bsy = (tgt == 0) ? bsy0 : bsy1;
  assign o_dn  = (tgt == 0) ? dn0  : dn1;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_act(input int narrow, input int fast, input int code);
    if (narrow == 0) return 17 - (code & 15);
    return (fast != 0) ? 8 - (code & 7) : 9 - (code & 7);
  endfunction

  function automatic int exp_rec(input int narrow, input int fast, input int code);
    int hi = (code >> 4) & 15;
    if (narrow == 0) return (15 - hi < 2) ? 2 : 15 - hi;
    return (fast != 0) ? 18 - hi : 15 - hi;
  endfunction

  function automatic logic [7:0] slot_addr(input int s, input logic [7:0] junk);
    logic [7:0] a = junk;
    a[7] = s[0];
    a[1] = s[1];
    return a;
  endfunction

  // called at a falling edge
  task automatic cfg_write(input int which, input logic [7:0] addr, input logic [7:0] data);
    cfg_addr = addr;
    cfg_data = data;
    if (which == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0;
    wr1 = 1'b0;
  endtask

  // called at a falling edge where the target is idle; returns at the falling edge after done
  task automatic access(input int which, input int sel, input int en, input int em,
                        input bit hold, input bit midwr, input logic [7:0] maddr,
                        input logic [7:0] mdata, input string tag);
    int n, m, bad;
    tgt = which;
    req_sel = 2'(sel);
    if (which == 0) v0 = 1'b1; else v1 = 1'b1;
    chk(o_rdy == 1'b1, {tag, " ready before access"}, int'(o_rdy), 1);
    @(negedge clk);
    if (!hold) begin v0 = 1'b0; v1 = 1'b0; end
    n = 0; bad = 0;
    while (o_stb == 1'b0 && n < 40) begin
      if (o_bsy !== 1'b1 || o_rdy !== 1'b0) bad++;
      if (midwr && n == 1) begin
        cfg_addr = maddr; cfg_data = mdata;
        if (which == 0) wr0 = 1'b1; else wr1 = 1'b1;
      end
      if (n == 2) begin wr0 = 1'b0; wr1 = 1'b0; end
      n++;
      @(negedge clk);
    end
    wr0 = 1'b0; wr1 = 1'b0;
    chk(n == en, {tag, " R6 active length"}, n, en);
    m = 0;
    while (o_dn == 1'b0 && m < 40) begin
      if (o_stb !== 1'b1 || o_bsy !== 1'b1 || o_rdy !== 1'b0) bad++;
      m++;
      @(negedge clk);
    end
    chk(m == em, {tag, " R6 recovery length"}, m, em);
    chk(bad == 0, {tag, " R10 busy/ready during access"}, bad, 0);
    chk(o_dn && !o_rdy && o_bsy && o_stb, {tag, " R8 done cycle"}, int'(o_rdy), 0);
    @(negedge clk);
    chk(o_rdy && !o_bsy && !o_dn && o_stb, {tag, " R8 ready after done"}, int'(o_rdy), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] codes [4];
    codes[0] = 8'h23; codes[1] = 8'h45; codes[2] = 8'h6A; codes[3] = 8'hB7;

    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk(rdy0 && stb0 && !bsy0 && !dn0, "R1 wide idle outputs", int'(rdy0), 1);
    chk(rdy1 && stb1 && !bsy1 && !dn1, "R1 narrow idle outputs", int'(rdy1), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents are code 0 in every slot
    for (int s = 0; s < 4; s++)
      access(0, s, 17, 15, 0, 0, 0, 0, "R1 wide slot");
    fast_bus = 1'b0;
    for (int s = 0; s < 4; s++)
      access(1, s, 9, 15, 0, 0, 0, 0, "R1 narrow slow slot");
    fast_bus = 1'b1;
    access(1, 2, 8, 18, 0, 0, 0, 0, "R1 narrow fast slot");
    fast_bus = 1'b0;

    // R2 slot addressing with junk in other address bits
    for (int s = 0; s < 4; s++)
      cfg_write(0, slot_addr(s, 8'h7D ^ 8'(s * 37)), codes[s]);
    for (int s = 0; s < 4; s++)
      access(0, s, exp_act(0, 0, int'(codes[s])), exp_rec(0, 0, int'(codes[s])),
             0, 0, 0, 0, "R2 slot select");

    // R3 wide sweep, strap toggled to show it has no effect
    for (int c = 0; c < 256; c++) begin
      fast_bus = c[0];
      cfg_write(0, slot_addr(c % 4, 8'(c)), 8'(c));
      access(0, c % 4, exp_act(0, 0, c), exp_rec(0, 0, c), 0, 0, 0, 0, "R3 wide code");
    end

    // R4 narrow slow sweep, R5 narrow fast sweep
    for (int f = 0; f < 2; f++) begin
      fast_bus = f[0];
      for (int c = 0; c < 256; c++) begin
        cfg_write(1, slot_addr(c % 4, 8'h55), 8'(c));
        access(1, c % 4, exp_act(1, f, c), exp_rec(1, f, c), 0, 0, 0, 0,
               (f == 0) ? "R4 narrow slow code" : "R5 narrow fast code");
      end
    end

    // R7 zero recovery goes straight to done
    fast_bus = 1'b0;
    cfg_write(1, slot_addr(3, 8'h00), 8'hF7);
    access(1, 3, 2, 0, 0, 0, 0, 0, "R7 zero recovery");
    cfg_write(1, slot_addr(0, 8'h00), 8'hF0);
    access(1, 0, 9, 0, 0, 0, 0, 0, "R7 zero recovery long active");

    // R8 held request: valid stays high through the first access
    cfg_write(0, slot_addr(1, 8'h00), 8'h3C);
    access(0, 1, 5, 12, 1, 0, 0, 0, "R8 held first");
    access(0, 1, 5, 12, 0, 0, 0, 0, "R8 held second");
    chk(rdy0 == 1'b1 && stb0 == 1'b1, "R8 no third access", int'(stb0), 1);

    // R9 writes during an access
    cfg_write(0, slot_addr(2, 8'h00), 8'h46);
    access(0, 2, 11, 11, 0, 1, slot_addr(2, 8'h14), 8'h46, "R9 same value mid write");
    access(0, 2, 11, 11, 0, 1, slot_addr(2, 8'h14), 8'h9E, "R9 new value mid write");
    access(0, 2, 3, 6, 0, 0, 0, 0, "R9 new value next access");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule